// File: doc/BRIEF.md
# Three-Wire Configuration Port for a Camera Front End

This block is the write-only serial configuration port of a camera analog front end. It runs on the system clock. It brings the serial clock, serial data and active-low frame enable lines into that clock domain and builds a 13-bit frame from them. The frame carries a 3-bit register address followed by a 10-bit data word, each sent most significant bit first. When the enable line returns high, a frame of exactly 13 bits is written into one of five control registers. A frame of any other length is dropped.

The registers drive parallel fields for the analog circuits:
- an 8-bit auxiliary DAC code;
- two 4-bit bandwidth codes;
- a 9-bit gain code, together with a copy of it limited to the highest code that changes the gain;
- a 6-bit control field for partial standby and pulse polarity;
- a 10-bit clamp-level code.

Data bits that a register does not use are reserved. A frame that sets any of them to 1 does not store them, and it raises a sticky error flag. A global standby input forces every field output to zero while it is high, but it does not disturb the stored values.

The frame is tracked by a four-state machine:
- `ST_IDLE` waits for the enable line to go low.
- `ST_SHIFT` takes in one bit on each synchronised rising edge of the serial clock.
- `ST_OVERRUN` is entered when a fourteenth bit arrives. It waits for release and then discards the frame.
- `ST_COMMIT` lasts one cycle and writes the addressed register.

The transitions are:
- *start*: `ST_IDLE` to `ST_SHIFT` when the enable line goes low.
- *shift*: `ST_SHIFT` stays in `ST_SHIFT` on each bit.
- *overflow*: `ST_SHIFT` to `ST_OVERRUN` on a fourteenth bit.
- *accept*: `ST_SHIFT` to `ST_COMMIT` on release with exactly 13 bits.
- *drop*: `ST_SHIFT` to `ST_IDLE` on release with fewer than 13 bits.
- *abandon*: `ST_OVERRUN` to `ST_IDLE` on release.
- *retire*: `ST_COMMIT` to `ST_IDLE`.

Top module: `cam_cfg_serial_port`

## Requirements
- R1: While reset is held and after it is released, every field output and the error flag read 0.
- R2: A frame is address A2..A0 followed by data D9..D0, each MSB first. A 13-bit frame takes effect only after the enable line rises.
- R3: Serial clock edges while the enable line is high shift nothing and change no output.
- R4: Address 000 loads D7..D0 into the auxiliary DAC code.
- R5: Address 001 loads D3..D0 into the CDS bandwidth code and D7..D4 into the AGC bandwidth code.
- R6: Address 010 loads D8..D0 into the gain code. The effective gain output equals the gain code up to 319 and reads 319 for every larger code.
- R7: Address 011 loads D5..D0 into the control field. Bit 0 is CDS/AGC standby, bit 1 is auxiliary DAC standby, bit 2 is amplifier standby, bit 3 selects falling-edge sample pulses, bit 4 selects active-high clamp pulses, and bit 5 at 0 selects the falling ADC clock edge.
- R8: Address 100 loads D9..D0 into the clamp-level code.
- R9: A frame with fewer or more than 13 bits changes no register and does not set the error flag.
- R10: Frames to addresses 101, 110 and 111 change no register and do not set the error flag.
- R11: The reserved bits are D9..D8 at address 000, D9..D8 at address 001, D9 at address 010 and D9..D6 at address 011. Any of them at 1 is not stored, and it sets the error flag. The flag then stays set until reset.
- R12: While the standby input is high, all field outputs read 0 and writes are still accepted. The stored values appear again when standby falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| sen_n_i | input | 1 | Active-low frame enable |
| standby_i | input | 1 | Global standby; blanks the field outputs |
| aux_code_o | output | 8 | Auxiliary DAC code |
| cds_bw_o | output | 4 | CDS bandwidth code |
| agc_bw_o | output | 4 | AGC bandwidth code |
| gain_code_o | output | 9 | Gain code as written |
| gain_eff_o | output | 9 | Gain code limited to 319 |
| ctrl_o | output | 6 | Standby and polarity control bits |
| clamp_code_o | output | 10 | Clamp-level code |
| rsv_err_o | output | 1 | Sticky reserved-bit error flag |

## Verification
The bench sweeps the following cases and, for each, names the fault it would expose:
- **Every gain code.** The boundary between 319 and 320 exposes an off-by-one limit or a limit that is not applied.
- **Every bandwidth byte and every control value.** These expose swapped nibbles or a shift that is out by one position.
- **Frames of 0, 12 and 14 bits.** A design that counted badly would write a shifted word.
- **Writes to the unused addresses.** A design that aliased them onto a real register would corrupt that register.
- **Reserved-bit writes.** These show whether a reserved bit leaks into a field or whether the error flag clears itself.
- **Serial clock toggling with the enable line high.** This exposes a port that shifts while the enable line is high.
- **Writes during standby.** These expose a port that blanks its storage instead of only its outputs.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 10;
    localparam int FRAME_W = ADDR_W + DATA_W;

    localparam int AUX_W   = 8;
    localparam int BW_W    = 4;
    localparam int GAIN_W  = 9;
    localparam int CTRL_W  = 6;
    localparam int CLAMP_W = 10;
    localparam int REGS_W  = AUX_W + 2 * BW_W + GAIN_W + CTRL_W + CLAMP_W;

    localparam logic [ADDR_W-1:0] ADDR_AUX   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_BW    = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_GAIN  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CLAMP = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_OVERRUN,
        ST_COMMIT
    } frame_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cam_cfg_pkg::*;
#(
    parameter int BITS = FRAME_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            sdat_s,
    input  logic            en_n_s,
    output logic            commit_o,
    output logic [BITS-1:0] word_o
);

    localparam int                CNT_W    = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BITS-1:0]  word_q;
    logic             sclk_prev_q;
    logic             sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!en_n_s) state_d = ST_SHIFT;                   // start
            end
            ST_SHIFT: begin
                if (en_n_s)
                    state_d = (cnt_q == CNT_FULL) ? ST_COMMIT      // accept
                                                  : ST_IDLE;       // drop
                else if (sclk_rise && cnt_q == CNT_FULL)
                    state_d = ST_OVERRUN;                          // overflow
            end
            ST_OVERRUN: begin
                if (en_n_s) state_d = ST_IDLE;                     // abandon
            end
            ST_COMMIT: state_d = ST_IDLE;                          // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            word_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == ST_SHIFT && !en_n_s && sclk_rise
                         && cnt_q != CNT_FULL) begin
                word_q <= {word_q[BITS-2:0], sdat_s};
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        commit_o = (state_q == ST_COMMIT);
        word_o   = word_q;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cam_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [AUX_W-1:0]   aux_q,
    output logic [BW_W-1:0]    cds_q,
    output logic [BW_W-1:0]    agc_q,
    output logic [GAIN_W-1:0]  gain_q,
    output logic [CTRL_W-1:0]  ctrl_q,
    output logic [CLAMP_W-1:0] clamp_q,
    output logic               err_q
);

    logic rsv_hit;

    always_comb begin
        case (addr_i)
            ADDR_AUX:  rsv_hit = |data_i[DATA_W-1:AUX_W];
            ADDR_BW:   rsv_hit = |data_i[DATA_W-1:2*BW_W];
            ADDR_GAIN: rsv_hit = |data_i[DATA_W-1:GAIN_W];
            ADDR_CTRL: rsv_hit = |data_i[DATA_W-1:CTRL_W];
            default:   rsv_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q   <= '0;
            cds_q   <= '0;
            agc_q   <= '0;
            gain_q  <= '0;
            ctrl_q  <= '0;
            clamp_q <= '0;
            err_q   <= 1'b0;
        end else if (commit_i) begin
            case (addr_i)
                ADDR_AUX:   aux_q   <= data_i[AUX_W-1:0];
                ADDR_BW: begin
                    cds_q <= data_i[BW_W-1:0];
                    agc_q <= data_i[2*BW_W-1:BW_W];
                end
                ADDR_GAIN:  gain_q  <= data_i[GAIN_W-1:0];
                ADDR_CTRL:  ctrl_q  <= data_i[CTRL_W-1:0];
                ADDR_CLAMP: clamp_q <= data_i[CLAMP_W-1:0];
                default: ;
            endcase
            err_q <= err_q | rsv_hit;
        end
    end

endmodule

// File: rtl/cam_cfg_serial_port.sv
module cam_cfg_serial_port
    import cam_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAIN_LIMIT  = 319
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdat_i,
    input  logic               sen_n_i,
    input  logic               standby_i,
    output logic [AUX_W-1:0]   aux_code_o,
    output logic [BW_W-1:0]    cds_bw_o,
    output logic [BW_W-1:0]    agc_bw_o,
    output logic [GAIN_W-1:0]  gain_code_o,
    output logic [GAIN_W-1:0]  gain_eff_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [CLAMP_W-1:0] clamp_code_o,
    output logic               rsv_err_o
);

    localparam logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(GAIN_LIMIT);

    logic [2:0]         sync_q;
    logic               sclk_s, sdat_s, en_n_s;
    logic               commit_stb;
    logic [FRAME_W-1:0] frame_word;
    logic [AUX_W-1:0]   aux_q;
    logic [BW_W-1:0]    cds_q, agc_q;
    logic [GAIN_W-1:0]  gain_q, gain_lim;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [CLAMP_W-1:0] clamp_q;
    logic               err_q;

    cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sen_n_i, sdat_i, sclk_i}),
        .q_o   (sync_q)
    );

    assign {en_n_s, sdat_s, sclk_s} = sync_q;

    cfg_frame_fsm #(
        .BITS (FRAME_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .sdat_s   (sdat_s),
        .en_n_s   (en_n_s),
        .commit_o (commit_stb),
        .word_o   (frame_word)
    );

    cfg_reg_bank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_stb),
        .addr_i   (frame_word[FRAME_W-1:DATA_W]),
        .data_i   (frame_word[DATA_W-1:0]),
        .aux_q    (aux_q),
        .cds_q    (cds_q),
        .agc_q    (agc_q),
        .gain_q   (gain_q),
        .ctrl_q   (ctrl_q),
        .clamp_q  (clamp_q),
        .err_q    (err_q)
    );

    assign gain_lim = (gain_q > GAIN_TOP) ? GAIN_TOP : gain_q;

    always_comb begin
        if (standby_i) begin
            aux_code_o   = '0;
            cds_bw_o     = '0;
            agc_bw_o     = '0;
            gain_code_o  = '0;
            gain_eff_o   = '0;
            ctrl_o       = '0;
            clamp_code_o = '0;
        end else begin
            aux_code_o   = aux_q;
            cds_bw_o     = cds_q;
            agc_bw_o     = agc_q;
            gain_code_o  = gain_q;
            gain_eff_o   = gain_lim;
            ctrl_o       = ctrl_q;
            clamp_code_o = clamp_q;
        end
        rsv_err_o = err_q;
    end

endmodule

// File: rtl/cam_cfg_serial_port_chk.sv
module cam_cfg_serial_port_chk
    import cam_cfg_pkg::*;
#(
    parameter int GAIN_LIMIT = 319
) (
    input logic               clk,
    input logic               rst_n,
    input logic               standby_i,
    input logic               en_n_s,
    input logic               commit_stb,
    input logic [ADDR_W-1:0]  commit_addr,
    input logic [REGS_W-1:0]  regs_q,
    input logic               err_q,
    input logic [AUX_W-1:0]   aux_code_o,
    input logic [BW_W-1:0]    cds_bw_o,
    input logic [BW_W-1:0]    agc_bw_o,
    input logic [GAIN_W-1:0]  gain_code_o,
    input logic [GAIN_W-1:0]  gain_eff_o,
    input logic [CTRL_W-1:0]  ctrl_o,
    input logic [CLAMP_W-1:0] clamp_code_o
);

    p_hold_without_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |=> $stable(regs_q));

    p_commit_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> en_n_s);

    p_gain_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_eff_o <= GAIN_W'(GAIN_LIMIT));

    p_gain_passthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && gain_code_o <= GAIN_W'(GAIN_LIMIT)) |-> gain_eff_o == gain_code_o);

    p_unused_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb && commit_addr > 3'd4) |=> ($stable(regs_q) && $stable(err_q)));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    p_standby_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> (aux_code_o == '0 && cds_bw_o == '0 && agc_bw_o == '0 &&
                       gain_code_o == '0 && gain_eff_o == '0 && ctrl_o == '0 &&
                       clamp_code_o == '0));

endmodule

bind cam_cfg_serial_port cam_cfg_serial_port_chk #(
    .GAIN_LIMIT (GAIN_LIMIT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby_i),
    .en_n_s       (en_n_s),
    .commit_stb   (commit_stb),
    .commit_addr  (frame_word[12:10]),
    .regs_q       ({aux_q, cds_q, agc_q, gain_q, ctrl_q, clamp_q}),
    .err_q        (err_q),
    .aux_code_o   (aux_code_o),
    .cds_bw_o     (cds_bw_o),
    .agc_bw_o     (agc_bw_o),
    .gain_code_o  (gain_code_o),
    .gain_eff_o   (gain_eff_o),
    .ctrl_o       (ctrl_o),
    .clamp_code_o (clamp_code_o)
);

// File: tb/cam_cfg_serial_port_tb_top.sv
module cam_cfg_serial_port_tb_top;

    logic clk = 1'b0;
    logic rst_n, sclk, sdat, sen_n, standby;
    logic [7:0] aux_code_o;
    logic [3:0] cds_bw_o, agc_bw_o;
    logic [8:0] gain_code_o, gain_eff_o;
    logic [5:0] ctrl_o;
    logic [9:0] clamp_code_o;
    logic       rsv_err_o;

    logic [7:0] e_aux;
    logic [3:0] e_cds, e_agc;
    logic [8:0] e_gain;
    logic [5:0] e_ctrl;
    logic [9:0] e_clamp;
    logic       e_err;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    cam_cfg_serial_port dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .sdat_i       (sdat),
        .sen_n_i      (sen_n),
        .standby_i    (standby),
        .aux_code_o   (aux_code_o),
        .cds_bw_o     (cds_bw_o),
        .agc_bw_o     (agc_bw_o),
        .gain_code_o  (gain_code_o),
        .gain_eff_o   (gain_eff_o),
        .ctrl_o       (ctrl_o),
        .clamp_code_o (clamp_code_o),
        .rsv_err_o    (rsv_err_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        e_aux = '0; e_cds = '0; e_agc = '0; e_gain = '0;
        e_ctrl = '0; e_clamp = '0; e_err = 1'b0;
    endtask

    task automatic send(input logic [12:0] w, input int nbits);
        sen_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            int j = 12 - i;
            sdat = (i < 13) ? w[j] : 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        tick(4);
        sen_n = 1'b1;
        tick(12);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [9:0] d);
        send({a, d}, 13);
        case (a)
            3'd0: begin e_aux = d[7:0]; e_err |= |d[9:8]; end
            3'd1: begin e_cds = d[3:0]; e_agc = d[7:4]; e_err |= |d[9:8]; end
            3'd2: begin e_gain = d[8:0]; e_err |= d[9]; end
            3'd3: begin e_ctrl = d[5:0]; e_err |= |d[9:6]; end
            3'd4: e_clamp = d;
            default: ;
        endcase
    endtask

    task automatic check(input string req);
        logic [50:0] act, exp;
        logic [8:0]  lim;
        lim = (e_gain > 9'd319) ? 9'd319 : e_gain;
        act = {aux_code_o, cds_bw_o, agc_bw_o, gain_code_o, gain_eff_o,
               ctrl_o, clamp_code_o, rsv_err_o};
        if (standby)
            exp = {50'd0, e_err};
        else
            exp = {e_aux, e_cds, e_agc, e_gain, lim, e_ctrl, e_clamp, e_err};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; sen_n = 1'b1; standby = 1'b0;
        model_reset();
        tick(5);
        check("R1 in reset");
        rst_n = 1'b1;
        tick(5);
        check("R1 after reset");

        // R4 auxiliary code
        foreach (aux_pat[k]) begin
            write_reg(3'd0, {2'b00, aux_pat[k]});
            check("R4 aux code");
        end

        // R5 every bandwidth byte
        for (int i = 0; i < 256; i++) begin
            write_reg(3'd1, 10'(i));
            check("R5 bandwidth");
        end

        // R6 every gain code, crossing the 319/320 limit
        for (int g = 0; g < 512; g++) begin
            write_reg(3'd2, 10'(g));
            check("R6 gain");
        end

        // R7 every control value
        for (int c = 0; c < 64; c++) begin
            write_reg(3'd3, 10'(c));
            check("R7 control");
        end

        // R8 / R2 clamp codes, full 10-bit width MSB first
        for (int k = 0; k < 1024; k += 31) begin
            write_reg(3'd4, 10'(k));
            check("R8 R2 clamp");
        end
        write_reg(3'd4, 10'h3FF);
        check("R8 R2 clamp max");

        // R3 serial clock with enable high
        sdat = 1'b1;
        for (int p = 0; p < 20; p++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        tick(10);
        check("R3 idle clocks");

        // R9 short, long and empty frames
        send({3'd4, 10'h155}, 12);
        check("R9 short frame");
        send({3'd4, 10'h0AA}, 14);
        check("R9 long frame");
        send({3'd0, 10'h3FF}, 0);
        check("R9 empty frame");

        // R10 unused addresses, including reserved-looking data
        write_reg(3'd5, 10'h3FF); check("R10 addr 5");
        write_reg(3'd6, 10'h2C1); check("R10 addr 6");
        write_reg(3'd7, 10'h100); check("R10 addr 7");

        // R11 reserved bits
        write_reg(3'd0, 10'h3C3); check("R11 aux reserved");
        write_reg(3'd4, 10'h000); check("R11 sticky");
        write_reg(3'd3, 10'h3C0); check("R11 ctrl reserved");
        write_reg(3'd1, 10'h25A); check("R11 bw reserved");
        write_reg(3'd2, 10'h3FF); check("R11 gain reserved");

        // R12 standby blanking
        standby = 1'b1; tick(2); check("R12 blanked");
        write_reg(3'd4, 10'h2AA); check("R12 write in standby");
        standby = 1'b0; tick(2); check("R12 restored");

        // R1 reset mid-run
        rst_n = 1'b0; model_reset(); tick(3); check("R1 reset again");
        rst_n = 1'b1; tick(3); check("R1 after second reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    logic [7:0] aux_pat [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

endmodule